// File: doc/BRIEF.md
# TDC Channel Coarse-Fine Timestamper

This block is one channel of a time-to-digital converter. An external delay line carries the hit edge through a chain of taps. Each tap feeds a flip-flop on the system clock, so every rising edge presents a thermometer vector. The block finds the hit in that vector and encodes how far the edge travelled into a binary fine code. It stamps the result with a coarse cycle count, tags it with a channel number and queues the word in a small FIFO. A downstream reader drains the FIFO.

Two coarse counters run half a clock period apart: one steps on the rising edge and one on the falling edge. Both are captured on every accepted hit. A selector uses the fine code to choose which captured value goes into the word. This keeps the coarse field safe for edges that arrive close to a clock transition.

Reset is active low and asynchronous. It must be released just after a rising edge, so that the half-period counter settles in step with the main counter. All logic, including the FIFO read side, runs on `clk`.

Top module: `tdc_stamp`

## Requirements
- R1: While reset is held and just after it is released, `empty` is 1, `full` is 0 and `overflow` is 0.
- R2: The fine field, word bits [7:0], holds the index of the highest tap that reads 1, from 0 to 127. Tap 0 is the first tap the edge reaches. Bit 7 is always 0.
- R3: Zeros inside the run of ones (bubbles) do not change the fine field. Only the highest set tap counts.
- R4: The coarse field, word bits [31:8], equals the number of rising edges since reset release that came before the sampling edge. This holds whether the fine value is below 64, where the falling-edge counter is used, or 64 and above, where the rising-edge counter is used.
- R5: Word bits [35:32] carry the channel number parameter, which is 5 by default.
- R6: A hit is accepted only in a cycle where the tap vector is non-zero and the vector in the previous cycle was all zero. A vector that stays non-zero over many cycles yields one word.
- R7: After an accepted hit, hits in the next two cycles are dropped. A hit three cycles later is accepted.
- R8: The FIFO shows its oldest word on `rd_data` whenever `empty` is 0. A cycle with `rd_en` high removes that word. Words leave in the order the hits came. `full` is 1 when all 8 entries hold words.
- R9: A hit that arrives while the FIFO is full is discarded and leaves the stored words unchanged. It sets `overflow`, which stays 1 until reset.
- R10: The word for a hit sampled at edge E is written at edge E+1. `empty` falls right after edge E+1 when the FIFO was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also samples the taps |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps | input | 128 | Thermometer vector from the tap flip-flops |
| rd_en | input | 1 | Pops the head word when `empty` is 0 |
| rd_data | output | 36 | Head word: channel, coarse, fine |
| empty | output | 1 | The FIFO holds no word |
| full | output | 1 | The FIFO holds 8 words |
| overflow | output | 1 | Sticky: a hit was lost to a full FIFO |

## Verification
A wrong internal state shows up in the first word read after it occurs.
- A corrupted coarse counter or a flipped selector makes the coarse field disagree with the bench's own edge count.
- A broken encoder shifts the fine field.
- A stuck dead-time counter or stuck previous-zero flag produces a missing or extra word. The bench catches this against its expected queue within a few cycles of the pulse.
- FIFO pointer faults reorder or repeat words at the next read.
- Lost overflow state shows on the sticky flag right after the first rejected hit.

// File: rtl/tdc_stamp.sv
module tdc_stamp #(
  parameter int TAPS       = 128,
  parameter int COARSE_W   = 24,
  parameter int CHAN_W     = 4,
  parameter int CHAN_ID    = 5,
  parameter int FINE_OUT_W = 8,
  parameter int DEPTH      = 8,
  parameter int DEAD       = 2,
  localparam int FINE_W    = $clog2(TAPS),
  localparam int WORD_W    = CHAN_W + COARSE_W + FINE_OUT_W,
  localparam int AW        = $clog2(DEPTH),
  localparam int DW        = $clog2(DEAD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAPS-1:0]   taps,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  localparam int HALF = TAPS / 2;

  logic [COARSE_W-1:0] cnt_a, cnt_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_a <= '0;
    else        cnt_a <= cnt_a + 1'b1;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cnt_b <= '1;
    else        cnt_b <= cnt_b + 1'b1;

  logic [FINE_W-1:0] fine_c;
  always_comb begin
    fine_c = '0;
    for (int i = 0; i < TAPS; i++)
      if (taps[i]) fine_c = FINE_W'(i);
  end

  logic          prev_zero, pend;
  logic [DW-1:0] dead_q;
  logic          hit_ok;
  logic [COARSE_W-1:0] lat_a, lat_b;
  logic [FINE_W-1:0]   lat_f;

  assign hit_ok = (|taps) && prev_zero && (dead_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_zero <= 1'b0;
      pend      <= 1'b0;
      dead_q    <= '0;
      lat_a     <= '0;
      lat_b     <= '0;
      lat_f     <= '0;
    end else begin
      prev_zero <= ~(|taps);
      pend      <= hit_ok;
      if (hit_ok) begin
        lat_a  <= cnt_a;
        lat_b  <= cnt_b;
        lat_f  <= fine_c;
        dead_q <= DW'(DEAD);
      end else if (dead_q != '0) begin
        dead_q <= dead_q - 1'b1;
      end
    end

  logic [COARSE_W-1:0] coarse_sel;
  logic [WORD_W-1:0]   word;
  assign coarse_sel = (int'(lat_f) < HALF) ? lat_b : lat_a;
  assign word       = {CHAN_W'(CHAN_ID), coarse_sel, FINE_OUT_W'(lat_f)};

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       fill;
  logic              do_wr, do_rd;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_wr   = pend && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk)
    if (do_wr) mem[wr_ptr] <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (pend && full) overflow <= 1'b1;
    end

endmodule

// File: rtl/tdc_stamp_chk.sv
module tdc_stamp_chk #(
  parameter int WORD_W     = 36,
  parameter int CHAN_W     = 4,
  parameter int CHAN_ID    = 5,
  parameter int FINE_OUT_W = 8,
  parameter int FINE_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              empty,
  input logic              full,
  input logic              overflow,
  input logic              rd_en,
  input logic              hit_ok,
  input logic [WORD_W-1:0] rd_data
);

  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R8

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9

  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(full)); // R9

  AST_CHAN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (rd_data[WORD_W-1 -: CHAN_W] == CHAN_W'(CHAN_ID))); // R5

  AST_FINE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (rd_data[FINE_OUT_W-1:FINE_W] == '0)); // R2

  AST_DEAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ok |=> !hit_ok); // R7

  AST_DEAD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_ok, 2) |-> !hit_ok); // R7

endmodule

bind tdc_stamp tdc_stamp_chk #(
  .WORD_W(WORD_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID),
  .FINE_OUT_W(FINE_OUT_W), .FINE_W(FINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .empty(empty), .full(full),
  .overflow(overflow), .rd_en(rd_en), .hit_ok(hit_ok), .rd_data(rd_data)
);

// File: tb/tdc_stamp_test.sv
`timescale 1ns/1ps
module tdc_stamp_test;
  localparam int TAPS = 128, DEPTH = 8, CID = 5, WW = 36;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TAPS-1:0] taps = '0;
  logic            rd_en = 1'b0;
  logic [WW-1:0]   rd_data;
  logic            empty, full, overflow;

  tdc_stamp uut (.clk(clk), .rst_n(rst_n), .taps(taps), .rd_en(rd_en),
                 .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, edges;
  logic [WW-1:0] expq[$];
  bit mon_on = 1'b1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0; else edges <= edges + 1;

  function automatic logic [TAPS-1:0] therm(int k);
    logic [TAPS-1:0] v = '0;
    for (int i = 0; i <= k; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [WW-1:0] mkword(int c, int f);
    return {4'(CID), 24'(c), 8'(f)};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R2 R3 R4 R5 R8
  always @(negedge clk) begin
    if (rst_n && mon_on && !empty) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R6/R7 unexpected word act=%h exp=none", rd_data);
      end else begin
        logic [WW-1:0] e;
        e = expq.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL R2/R3/R4/R5/R8 word act=%h exp=%h", rd_data, e);
        end
      end
      rd_en = 1'b1;
    end else rd_en = 1'b0;
  end

  task automatic pulse(logic [TAPS-1:0] v, int f, bit acc);
    @(negedge clk);
    taps = v;
    if (acc) expq.push_back(mkword(edges, f));
    @(negedge clk);
    taps = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(string tag);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, tag, expq.size(), 0);
    chk(empty == 1'b1, tag, empty, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    taps  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0 && overflow == 1'b0, "R1 in reset",
        {empty, full, overflow}, 3'b100);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R10 watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R10 write latency
    @(negedge clk);
    taps = therm(10);
    expq.push_back(mkword(edges, 10));
    @(negedge clk);
    taps = '0;
    chk(empty == 1'b1, "R10 still empty after sampling edge", empty, 1);
    @(negedge clk);
    chk(empty == 1'b0, "R10 word present one edge later", empty, 0);
    repeat (3) @(negedge clk);

    // R2 R4 both halves of the fine range
    pulse(therm(0), 0, 1'b1);
    pulse(therm(63), 63, 1'b1);
    pulse(therm(64), 64, 1'b1);
    pulse(therm(127), 127, 1'b1);

    // R3 bubbles
    begin
      logic [TAPS-1:0] v;
      v = therm(40); v[20] = 1'b0; v[30] = 1'b0; v[50] = 1'b1;
      pulse(v, 50, 1'b1);
      v = therm(100); v[99] = 1'b0; v[70] = 1'b0;
      pulse(v, 100, 1'b1);
    end
    drain("R2/R3/R4 drain");

    // R6 held vector gives one word
    @(negedge clk);
    taps = therm(20);
    expq.push_back(mkword(edges, 20));
    repeat (6) @(negedge clk);
    taps = '0;
    drain("R6 held hit single word");

    // R7 dead time: hit two cycles later dropped, four later kept
    @(negedge clk);
    taps = therm(5);
    expq.push_back(mkword(edges, 5));
    @(negedge clk) taps = '0;
    @(negedge clk) taps = therm(6);
    @(negedge clk) taps = '0;
    @(negedge clk);
    taps = therm(7);
    expq.push_back(mkword(edges, 7));
    @(negedge clk) taps = '0;
    drain("R7 dropped inside dead time");

    // R7 hit three cycles later accepted
    @(negedge clk);
    taps = therm(8);
    expq.push_back(mkword(edges, 8));
    @(negedge clk) taps = '0;
    @(negedge clk);
    @(negedge clk);
    taps = therm(9);
    expq.push_back(mkword(edges, 9));
    @(negedge clk) taps = '0;
    drain("R7 accepted after dead time");

    // R8 R9 fill and overflow
    mon_on = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (i == DEPTH) begin
        chk(full == 1'b1, "R8 full at depth", full, 1);
        chk(overflow == 1'b0, "R9 no overflow yet", overflow, 0);
      end
      pulse(therm(i + 1), i + 1, i < DEPTH);
    end
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    mon_on = 1'b1;
    drain("R9 stored words intact");
    chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    // R1 R9 reset clears, R4 coarse restarts
    do_reset();
    chk(overflow == 1'b0, "R9 cleared by reset", overflow, 0);
    pulse(therm(33), 33, 1'b1);
    pulse(therm(90), 90, 1'b1);
    drain("R4 after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule